// File: doc/BRIEF.md
# I/O Bus Cycle Address Generator

This block sits between a processor core and an external byte-wide bus. It takes a single request for an I/O port access and runs it out as one or two byte bus cycles. Each request carries five things: a direction, an addressing mode, an 8-bit immediate port number, a 16-bit pointer value and a size.

In direct mode, the immediate port number is zero-extended into the first 256-byte page of I/O space. In variable mode, the pointer value is used whole as the port address. The 20-bit address bus always carries zeros on its top four lines during I/O work. A word is split into two byte cycles: the low byte is transferred at the base port and the high byte at the next port.

Every byte cycle lasts four clocks, named T1 to T4. During those four clocks the block holds the address, the I/O status code and the write byte. It collects read bytes at the end of T3. When the request is complete, it raises a one-clock done pulse.

Top module: `io_cycle_gen`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready` is 1, `bus_status` is 3'b111 (passive), `bus_addr` is 0, `bus_wdata` is 0 and `done` is 0.
- R2: In direct mode (`req_var`=0), the 16-bit port address is {8'h00, `req_port`}, and `req_ptr` has no effect.
- R3: In variable mode (`req_var`=1), the 16-bit port address is `req_ptr`, and `req_port` has no effect.
- R4: During every bus cycle, `bus_addr[19:16]` is 0 and `bus_addr[15:0]` carries the port address of the byte being transferred.
- R5: During all four clocks of a bus cycle, `bus_status` is 3'b001 for a read and 3'b010 for a write.
- R6: Each byte cycle lasts exactly four clocks. The first clock follows the edge that accepted the request, or the edge that ended the previous byte cycle. Address, status and write byte stay stable through the cycle.
- R7: A word request (`req_word`=1) runs a low-byte cycle at the base address, then a high-byte cycle at base+1, wrapping within 16 bits (FFFF is followed by 0000). `bus_wdata` carries `req_wdata[7:0]`, then `req_wdata[15:8]`. A byte request runs one cycle with `req_wdata[7:0]`. `bus_wdata` is 0 during reads.
- R8: The read byte is the value of `bus_rdata` at the clock edge that ends the third clock of its cycle. `rd_data` holds {high byte, low byte}. It is cleared when a request is accepted, so it stays 0 for writes, and its high byte stays 0 for byte reads.
- R9: `done` is high for exactly one clock, in the clock after the last T4. `req_ready` is already 1 in that clock. A request presented while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken only while `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_var | input | 1 | 1 = address from pointer, 0 = immediate page-0 port |
| req_port | input | 8 | Immediate port number |
| req_ptr | input | 16 | Pointer register value |
| req_word | input | 1 | 1 = two bytes, 0 = one byte |
| req_wdata | input | 16 | Write data, low byte sent first |
| req_ready | output | 1 | Block is idle and accepts a request |
| bus_addr | output | 20 | Bus address |
| bus_status | output | 3 | Cycle status code |
| bus_wdata | output | 8 | Write byte on the bus |
| bus_rdata | input | 8 | Read byte from the bus |
| rd_data | output | 16 | Collected read data |
| done | output | 1 | One-clock completion pulse |

## Verification
The assertions rely on reset being applied before the first request. Beyond that, they assume only that requests arrive as plain one-clock strobes; `bus_rdata` may take any value at any time. The stimulus deliberately changes `bus_rdata` in every clock except the sampling one, so the sampling edge is pinned down. It also presents a conflicting request in the middle of each transfer, so the busy-time gating is exercised and never skirted. Requests are issued only when `req_ready` is seen high. The strobe is dropped before the done clock, so the deliberate mid-transfer request never becomes a real one.

// File: rtl/io_cycle_gen.sv
module io_cycle_gen (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_var,
  input  logic [7:0]  req_port,
  input  logic [15:0] req_ptr,
  input  logic        req_word,
  input  logic [15:0] req_wdata,
  output logic        req_ready,
  output logic [19:0] bus_addr,
  output logic [2:0]  bus_status,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic [15:0] rd_data,
  output logic        done
);
  localparam logic [2:0] ST_RD   = 3'b001;
  localparam logic [2:0] ST_WR   = 3'b010;
  localparam logic [2:0] ST_IDLE = 3'b111;
  localparam logic [1:0] T3 = 2'd2;
  localparam logic [1:0] T4 = 2'd3;

  logic        busy, wr, word, hi, done_q;
  logic [1:0]  tst;
  logic [15:0] base, wdat, rdat;
  logic [15:0] cur;

  assign cur        = base + {15'd0, hi};
  assign req_ready  = !busy;
  assign bus_addr   = busy ? {4'h0, cur} : 20'h0;
  assign bus_status = !busy ? ST_IDLE : (wr ? ST_WR : ST_RD);
  assign bus_wdata  = (busy && wr) ? (hi ? wdat[15:8] : wdat[7:0]) : 8'h00;
  assign rd_data    = rdat;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      wr     <= 1'b0;
      word   <= 1'b0;
      hi     <= 1'b0;
      done_q <= 1'b0;
      tst    <= 2'd0;
      base   <= 16'h0;
      wdat   <= 16'h0;
      rdat   <= 16'h0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1;
          tst  <= 2'd0;
          hi   <= 1'b0;
          wr   <= req_write;
          word <= req_word;
          base <= req_var ? req_ptr : {8'h00, req_port};
          wdat <= req_wdata;
          rdat <= 16'h0;
        end
      end else begin
        tst <= tst + 2'd1;
        if (tst == T3 && !wr) begin
          if (hi) rdat[15:8] <= bus_rdata;
          else    rdat[7:0]  <= bus_rdata;
        end
        if (tst == T4) begin
          if (word && !hi) begin
            hi <= 1'b1;
          end else begin
            busy   <= 1'b0;
            hi     <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module io_cycle_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        ready,
  input logic        done,
  input logic [19:0] bus_addr,
  input logic [2:0]  bus_status,
  input logic [7:0]  bus_wdata,
  input logic [1:0]  tst,
  input logic        hi
);
  a_r1_passive_idle: assert property (@(posedge clk) disable iff (rst)
    ready |-> (bus_status == 3'b111 && bus_addr == 20'h0 && bus_wdata == 8'h00));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_addr[19:16] == 4'h0);

  a_r5_io_status: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (bus_status == 3'b001 || bus_status == 3'b010));

  a_r6_stable_in_cycle: assert property (@(posedge clk) disable iff (rst)
    (!ready && tst != 2'd0) |-> ($stable(bus_addr) && $stable(bus_status) && $stable(bus_wdata)));

  a_r7_next_port: assert property (@(posedge clk) disable iff (rst)
    (!ready && tst == 2'd0 && hi) |-> (bus_addr[15:0] == 16'($past(bus_addr[15:0]) + 16'd1)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  a_r9_done_after_t4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(tst) == 2'd3 && !$past(ready)));
endmodule

bind io_cycle_gen io_cycle_gen_chk u_chk (
  .clk(clk), .rst(rst), .ready(req_ready), .done(done),
  .bus_addr(bus_addr), .bus_status(bus_status), .bus_wdata(bus_wdata),
  .tst(tst), .hi(hi)
);

// File: tb/tb_io_cycle_gen.sv
module tb_io_cycle_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_var = 1'b0, req_word = 1'b0;
  logic [7:0]  req_port = 8'h0;
  logic [15:0] req_ptr = 16'h0, req_wdata = 16'h0;
  logic        req_ready, done;
  logic [19:0] bus_addr;
  logic [2:0]  bus_status;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = 8'h0;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  io_cycle_gen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_var(req_var), .req_port(req_port), .req_ptr(req_ptr),
    .req_word(req_word), .req_wdata(req_wdata), .req_ready(req_ready),
    .bus_addr(bus_addr), .bus_status(bus_status), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rd_data(rd_data), .done(done)
  );

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input bit w, input bit v, input logic [7:0] port,
                         input logic [15:0] ptr, input bit wd, input logic [15:0] wdata);
    logic [15:0] base, a, exp_rd;
    logic [2:0]  exp_st;
    logic [7:0]  exp_wb;
    int nb;
    base   = v ? ptr : {8'h00, port};
    exp_st = w ? 3'b010 : 3'b001;
    nb     = wd ? 2 : 1;
    exp_rd = 16'h0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = w; req_var = v; req_port = port;
    req_ptr = ptr; req_word = wd; req_wdata = wdata;
    for (int b = 0; b < nb; b++) begin
      a = base + 16'(b);
      exp_wb = !w ? 8'h00 : (b == 1 ? wdata[15:8] : wdata[7:0]);
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        if (b == 0 && t == 0) req_valid = 1'b0;
        chk(bus_addr == {4'h0, a}, v ? "R3 R4 R7 address" : "R2 R4 R7 address", {12'd0, bus_addr}, {16'd0, a});
        chk(bus_status == exp_st && req_ready == 1'b0, "R5 R6 status in cycle", {29'd0, bus_status}, {29'd0, exp_st});
        chk(bus_wdata == exp_wb, "R7 write byte", {24'd0, bus_wdata}, {24'd0, exp_wb});
        chk(done == 1'b0, "R9 no early done", {31'd0, done}, 32'd0);
        bus_rdata = (t == 2) ? pattern(a) : ~pattern(a);
        if (b == 0 && t == 1) begin
          req_valid = 1'b1; req_write = ~w; req_var = ~v;
          req_port = ~port; req_ptr = ~ptr; req_word = ~wd; req_wdata = ~wdata;
        end
        if (t == 2) req_valid = 1'b0;
      end
      if (!w) begin
        if (b == 1) exp_rd[15:8] = pattern(a);
        else        exp_rd[7:0]  = pattern(a);
      end
    end
    @(negedge clk);
    chk(done == 1'b1, "R6 R9 done after last T4", {31'd0, done}, 32'd1);
    chk(req_ready == 1'b1 && bus_status == 3'b111 && bus_addr == 20'h0, "R1 R9 idle at done",
        {12'd0, bus_addr}, 32'd0);
    chk(rd_data == exp_rd, "R8 read data", {16'd0, rd_data}, {16'd0, exp_rd});
    @(negedge clk);
    chk(done == 1'b0, "R9 done single pulse", {31'd0, done}, 32'd0);
    chk(req_ready == 1'b1 && bus_status == 3'b111, "R9 busy-time request ignored",
        {29'd0, bus_status}, 32'd7);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R1 reset ready/done", {30'd0, req_ready, done}, 32'd2);
    chk(bus_status == 3'b111, "R1 reset status", {29'd0, bus_status}, 32'd7);
    chk(bus_addr == 20'h0 && bus_wdata == 8'h0, "R1 reset address", {12'd0, bus_addr}, 32'd0);
    for (int i = 0; i < 256; i++)
      run_req(i[0], 1'b0, i[7:0], 16'(i * 16'h0F3B), i[1], 16'(i * 16'h3C71 + 16'h0102));
    for (int i = 0; i < 64; i++)
      run_req(i[1], 1'b1, 8'(i * 7), 16'(i * 16'h0407) ^ 16'h1F00, i[0] ^ i[2], 16'(i * 16'h2B4D));
    run_req(1'b0, 1'b1, 8'h11, 16'hFFFF, 1'b1, 16'h0000);
    run_req(1'b1, 1'b1, 8'h22, 16'hFFFF, 1'b1, 16'hBEEF);
    run_req(1'b0, 1'b0, 8'hFF, 16'hFFFF, 1'b1, 16'h0000);
    run_req(1'b1, 1'b1, 8'h00, 16'h0000, 1'b0, 16'hA55A);
    run_req(1'b0, 1'b1, 8'hFF, 16'h00FF, 1'b1, 16'h0000);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule